// File: doc/BRIEF.md
# TCP segmentation header rewriter

This block turns one large TCP/IP send into a train of wire-sized frames. A context command first sets the header length, the maximum segment size (MSS), the total payload length and whether the flow is TCP. The block then takes exactly one prototype header (Ethernet, IP and TCP bytes) on a header byte stream and keeps it in flop storage. After that it emits segments on a byte-wide output stream. Each segment is the stored header followed by the next slice of payload taken from a payload byte stream. That payload stream may come from several buffers and may pause between them.

While each header is replayed, the block rewrites four fields on the fly. The IP identification becomes the prototype value plus the segment number. The IP total length is recomputed for the segment. The TCP sequence number advances by the payload already sent. FIN and PSH are cleared on every segment but the final one. Checksums are left to a later stage. Preconditions: MSS is at least 1, and the header length covers the fields that are patched.

Top module: `tso_segmenter`

## Requirements
- R1: A context command is taken only while `ctx_ready` is high, which is the case after reset and after a job ends. A `ctx_valid` pulse while busy has no effect on the frames that are emitted.
- R2: After a context, exactly header-length bytes are accepted on the header stream. `hdr_ready` then stays low even if `hdr_valid` is held high, and no output byte appears while the header is being captured.
- R3: Every segment is the header-length stored bytes followed by its payload. `out_sop` marks the first byte and `out_eop` the last. The byte after an end is either idle or a new start. After the final segment `ctx_ready` returns high.
- R4: Segment payload is min(MSS, payload bytes remaining), taken in order from the payload stream regardless of pauses on that stream. A segment closes at MSS + header length, or when all payload is used.
- R5: Frame bytes 18..19 (IP ID, big-endian) carry the prototype ID plus k, where k = 0 for the first segment, modulo 2^16.
- R6: Frame bytes 16..17 (IP total length, big-endian) carry the segment length minus 14.
- R7: With T = 14 + 4 × (low nibble of frame byte 14), bytes T+4..T+7 (big-endian) carry the prototype TCP sequence plus the payload bytes sent in earlier segments.
- R8: Byte T+13 (TCP flags) is ANDed with 0xF6 (FIN bit 0 and PSH bit 3 cleared) on every segment except the last. The last segment keeps the prototype value.
- R9: When the context is not TCP, bytes T+4..T+7 and T+13 pass through unchanged, while R5 and R6 still apply.
- R10: Segment number and sent-byte count restart on each context, so a second job again starts at the prototype ID and sequence.
- R11: While `out_ready` is low, a header byte on the output is held stable and no payload byte is consumed. No payload byte is lost or duplicated.
- R12: A context with total payload length 0 captures the header, emits nothing, and returns to ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_valid | input | 1 | Context command present |
| ctx_ready | output | 1 | Block idle, context accepted |
| ctx_hdr_len | input | LW | Prototype header length in bytes |
| ctx_mss | input | LW | Maximum payload bytes per segment |
| ctx_total | input | LW | Total payload bytes of the job |
| ctx_tcp | input | 1 | Flow is TCP (enables sequence/flag rewrite) |
| hdr_valid | input | 1 | Prototype header byte present |
| hdr_ready | output | 1 | Header byte accepted |
| hdr_data | input | 8 | Prototype header byte |
| pl_valid | input | 1 | Payload byte present |
| pl_ready | output | 1 | Payload byte accepted |
| pl_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a segment |
| out_eop | output | 1 | Last byte of a segment |

## Verification
Two events can land on the same clock edge: the close of one segment (its last payload byte is accepted, the segment number and sent count advance) and the switch back to header replay for the next one. That next header is patched from the counters updated on that same edge. The bench provokes this with back-to-back segments at full rate, with gapped payload and with an irregular `out_ready` pattern. It judges every byte of every segment against a model built from R4–R8: a stale or early counter value shows up as a wrong ID, length or sequence in the following header. A junk context pulse during streaming and a held-high header valid confirm that neither interferes.

// File: rtl/tso_segmenter.sv
module tso_segmenter #(
  parameter int LW      = 16,
  parameter int HDR_MAX = 128,
  parameter int ETH_HDR = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctx_valid,
  output logic          ctx_ready,
  input  logic [LW-1:0] ctx_hdr_len,
  input  logic [LW-1:0] ctx_mss,
  input  logic [LW-1:0] ctx_total,
  input  logic          ctx_tcp,
  input  logic          hdr_valid,
  output logic          hdr_ready,
  input  logic [7:0]    hdr_data,
  input  logic          pl_valid,
  output logic          pl_ready,
  input  logic [7:0]    pl_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_sop,
  output logic          out_eop
);
  localparam int AW = $clog2(HDR_MAX);

  typedef enum logic [1:0] {S_IDLE, S_CAP, S_HDR, S_PAY} st_t;
  st_t st;

  logic [LW-1:0] hdr_q, mss_q, tot_q, idx, sent;
  logic [15:0]   segk;
  logic          tcp_q;
  logic [7:0]    mem [HDR_MAX];

  logic [LW-1:0] rem, seg_pay, seg_len, ip_len;
  logic          is_last;
  logic [AW-1:0] hi, tp, off;
  logic [15:0]   id_v;
  logic [31:0]   seq_v;
  logic [7:0]    hb;

  assign rem     = tot_q - sent;
  assign is_last = rem <= mss_q;
  assign seg_pay = is_last ? rem : mss_q;
  assign seg_len = hdr_q + seg_pay;
  assign ip_len  = seg_len - LW'(ETH_HDR);

  assign hi   = idx[AW-1:0];
  assign tp   = AW'(ETH_HDR) + AW'({mem[ETH_HDR][3:0], 2'b00});
  assign off  = hi - tp;
  assign id_v = {mem[ETH_HDR+4], mem[ETH_HDR+5]} + segk;
  assign seq_v = {mem[tp+AW'(4)], mem[tp+AW'(5)], mem[tp+AW'(6)], mem[tp+AW'(7)]}
               + 32'(sent);

  always_comb begin
    hb = mem[hi];
    if (hi == AW'(ETH_HDR+2))      hb = ip_len[15:8];
    else if (hi == AW'(ETH_HDR+3)) hb = ip_len[7:0];
    else if (hi == AW'(ETH_HDR+4)) hb = id_v[15:8];
    else if (hi == AW'(ETH_HDR+5)) hb = id_v[7:0];
    else if (tcp_q && hi >= tp) begin
      case (off)
        AW'(4):  hb = seq_v[31:24];
        AW'(5):  hb = seq_v[23:16];
        AW'(6):  hb = seq_v[15:8];
        AW'(7):  hb = seq_v[7:0];
        AW'(13): if (!is_last) hb = mem[hi] & 8'hF6;
        default: ;
      endcase
    end
  end

  assign ctx_ready = st == S_IDLE;
  assign hdr_ready = st == S_CAP;
  assign pl_ready  = st == S_PAY && out_ready;
  assign out_valid = st == S_HDR || (st == S_PAY && pl_valid);
  assign out_data  = st == S_HDR ? hb : pl_data;
  assign out_sop   = st == S_HDR && idx == '0;
  assign out_eop   = st == S_PAY && idx == seg_len - LW'(1);

  always_ff @(posedge clk) begin
    if (st == S_CAP && hdr_valid) mem[hi] <= hdr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      hdr_q <= '0;
      mss_q <= '0;
      tot_q <= '0;
      tcp_q <= 1'b0;
      idx   <= '0;
      sent  <= '0;
      segk  <= '0;
    end else begin
      case (st)
        S_IDLE: if (ctx_valid) begin
          hdr_q <= ctx_hdr_len;
          mss_q <= ctx_mss;
          tot_q <= ctx_total;
          tcp_q <= ctx_tcp;
          idx   <= '0;
          sent  <= '0;
          segk  <= '0;
          st    <= S_CAP;
        end
        S_CAP: if (hdr_valid) begin
          if (idx == hdr_q - LW'(1)) begin
            idx <= '0;
            st  <= (tot_q == '0) ? S_IDLE : S_HDR;
          end else idx <= idx + LW'(1);
        end
        S_HDR: if (out_ready) begin
          if (idx == hdr_q - LW'(1)) st <= S_PAY;
          idx <= idx + LW'(1);
        end
        S_PAY: if (pl_valid && out_ready) begin
          if (out_eop) begin
            idx  <= '0;
            sent <= sent + seg_pay;
            segk <= segk + 16'd1;
            st   <= is_last ? S_IDLE : S_HDR;
          end else idx <= idx + LW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_busy_ctx_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_valid && !ctx_ready) |=> ($stable(tot_q) && $stable(mss_q) && $stable(hdr_q)));

  assert_capture_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ready |-> !out_valid);

  assert_start_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> (!out_valid || out_sop));

  assert_ready_after_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop && is_last) |=> ctx_ready);

  assert_sent_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sent <= tot_q);

  assert_hdr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready) |-> (out_valid && out_ready));
endmodule

// File: tb/tso_segmenter_test.sv
`timescale 1ns/1ps
module tso_segmenter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctx_valid = 1'b0, ctx_tcp = 1'b0;
  logic [15:0] ctx_hdr_len = '0, ctx_mss = '0, ctx_total = '0;
  logic        hdr_valid = 1'b0, pl_valid = 1'b0, out_ready = 1'b0;
  logic [7:0]  hdr_data = '0, pl_data = '0;
  logic        ctx_ready, hdr_ready, pl_ready, out_valid, out_sop, out_eop;
  logic [7:0]  out_data;

  int checks = 0, bad = 0;
  logic [7:0] hb [256];
  int g_hl, g_ihl, g_mss, g_tot;
  bit g_tcp;

  always #2.5 clk = ~clk;

  tso_segmenter uut (
    .clk(clk), .rst_n(rst_n),
    .ctx_valid(ctx_valid), .ctx_ready(ctx_ready),
    .ctx_hdr_len(ctx_hdr_len), .ctx_mss(ctx_mss), .ctx_total(ctx_total), .ctx_tcp(ctx_tcp),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  function automatic logic [7:0] pay_byte(int n);
    return 8'(n * 13 + 5);
  endfunction

  function automatic int tcp_off();
    return 14 + 4 * g_ihl;
  endfunction

  function automatic logic [7:0] exp_byte(int k, int j, int sent, int pay);
    int t = tcp_off();
    bit last = (g_tot - sent) <= g_mss;
    logic [15:0] len = 16'(g_hl + pay - 14);
    logic [15:0] id = 16'({hb[18], hb[19]} + k);
    logic [31:0] sq = {hb[t+4], hb[t+5], hb[t+6], hb[t+7]} + 32'(sent);
    if (j >= g_hl) return pay_byte(sent + j - g_hl);
    if (j == 16) return len[15:8];
    if (j == 17) return len[7:0];
    if (j == 18) return id[15:8];
    if (j == 19) return id[7:0];
    if (g_tcp && j >= t + 4 && j <= t + 7) return 8'(sq >> (8 * (t + 7 - j)));
    if (g_tcp && j == t + 13 && !last) return hb[j] & 8'hF6;
    return hb[j];
  endfunction

  function automatic string tag_of(int j);
    int t = tcp_off();
    if (j >= g_hl) return "R4";
    if (j == 16 || j == 17) return "R6";
    if (j == 18 || j == 19) return "R5";
    if (j >= t + 4 && j <= t + 7) return g_tcp ? "R7" : "R9";
    if (j == t + 13) return g_tcp ? "R8" : "R9";
    return "R3";
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ctx_ready == 1'b1, "R1", "ctx_ready after reset", ctx_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(hdr_ready == 1'b0 && pl_ready == 1'b0, "R1", "input readies after reset",
        {hdr_ready, pl_ready}, 0);
  endtask

  // one full job; every output byte is compared with the model
  task automatic run_job(int hl, int ihl, int mss, int tot, bit tcp,
                         bit stall, bit gaps, bit poke);
    int t, nseg, k, j, sent, pay, hp, pp, cyc;
    logic [7:0] e;
    g_hl = hl; g_ihl = ihl; g_mss = mss; g_tot = tot; g_tcp = tcp;
    t = tcp_off();
    for (int i = 0; i < 256; i++) hb[i] = 8'(i * 7 + 3 + hl);
    hb[14] = {4'h4, 4'(ihl)};
    hb[t + 13] = 8'h19;
    nseg = (tot == 0) ? 0 : (tot + mss - 1) / mss;
    k = 0; j = 0; sent = 0; hp = 0; pp = 0; cyc = 0;
    pay = (tot < mss) ? tot : mss;

    @(negedge clk);
    chk(ctx_ready == 1'b1, "R1", "ready before context", ctx_ready, 1);
    ctx_valid = 1'b1; ctx_hdr_len = 16'(hl); ctx_mss = 16'(mss);
    ctx_total = 16'(tot); ctx_tcp = tcp;
    @(posedge clk);
    #1 ctx_valid = 1'b0;
    hdr_valid = 1'b1; hdr_data = hb[0];
    out_ready = 1'b1;

    forever begin
      @(negedge clk);
      if (hdr_valid && hdr_ready) hp++;
      if (pl_valid && pl_ready) pp++;
      if (out_valid && out_ready) begin
        if (k >= nseg) begin
          chk(1'b0, (tot == 0) ? "R12" : "R3", "byte beyond last segment", out_data, 0);
        end else begin
          e = exp_byte(k, j, sent, pay);
          chk(out_data == e, tag_of(j), $sformatf("seg %0d byte %0d", k, j), out_data, e);
          chk(out_sop == (j == 0), "R3", $sformatf("sop seg %0d byte %0d", k, j),
              out_sop, (j == 0));
          chk(out_eop == (j == hl + pay - 1), "R3", $sformatf("eop seg %0d byte %0d", k, j),
              out_eop, (j == hl + pay - 1));
          j++;
          if (j == hl + pay) begin
            j = 0; sent += pay; k++;
            pay = ((tot - sent) < mss) ? (tot - sent) : mss;
          end
        end
      end
      if (k == nseg && hp >= hl && ctx_ready) break;
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "R3", "job did not finish", k, nseg);
        break;
      end
      @(posedge clk);
      #1;
      hdr_valid = 1'b1;
      hdr_data  = hb[hp < 255 ? hp : 255];
      pl_valid  = (pp < tot) && !(gaps && (cyc % 7 == 3));
      pl_data   = pay_byte(pp);
      out_ready = !(stall && (cyc % 3 == 1));
      if (poke && cyc == 15) begin
        ctx_valid = 1'b1; ctx_hdr_len = 16'd3; ctx_mss = 16'd1;
        ctx_total = 16'd999; ctx_tcp = ~tcp;
      end else ctx_valid = 1'b0;
    end
    hdr_valid = 1'b0; pl_valid = 1'b0; ctx_valid = 1'b0;
    // R2: held-high header valid must not pull more than hl bytes
    chk(hp == hl, "R2", "header bytes accepted", hp, hl);
    chk(pp == tot, "R4", "payload bytes consumed", pp, tot);
    chk(k == nseg, "R3", "segments emitted", k, nseg);
  endtask

  task automatic t_basic();       run_job(54, 5, 100, 250, 1, 0, 0, 0); endtask
  task automatic t_exact_fit();   run_job(54, 5, 100, 200, 1, 0, 0, 0); endtask
  task automatic t_backpressure();run_job(54, 5, 64, 300, 1, 1, 1, 0); endtask
  task automatic t_udp();         run_job(42, 5, 50, 120, 0, 0, 1, 0); endtask
  task automatic t_ip_options();  run_job(58, 6, 40, 130, 1, 1, 0, 0); endtask
  task automatic t_busy_ctx();    run_job(54, 5, 30, 100, 1, 0, 0, 1); endtask // R1
  task automatic t_restart();     run_job(54, 5, 100, 250, 1, 0, 1, 0); endtask // R10
  task automatic t_empty();       run_job(54, 5, 100, 0, 1, 0, 0, 0); endtask   // R12
  task automatic t_single();      run_job(54, 5, 1000, 77, 1, 1, 0, 0); endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_exact_fit();
    t_backpressure();
    t_udp();
    t_ip_options();
    t_busy_ctx();
    t_restart();
    t_empty();
    t_single();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule